// File: doc/BRIEF.md
# Serial Zero-Insertion Framer and Deframer

This block pairs a transmit framer and a receive deframer for bit-serial links that mark frame boundaries with a reserved flag pattern. On the transmit side a source hands in payload bits one at a time with a valid/ready handshake and marks the final bit of each frame. The framer wraps the frame in flags. Inside the payload it adds a zero after any five ones in a row, so the flag can never appear in the data.

The receive side takes line bits as they arrive, with a qualifier and no back-pressure. It finds flags, strips the inserted zeros, and hands the recovered payload bits out with strobes that mark the first bit and the end of each frame. A run of ones longer than a flag ends the current frame with an abort strobe. The two halves are independent and can be looped back to each other.

Top module: `hdlc_bit_framer`

## Requirements
- R1: In the transmitted payload, a 0 is placed on the line directly after every fifth consecutive payload 1. This includes the case where that fifth 1 is the last payload bit.
- R2: The transmit input holds `s_ready` low for exactly one cycle for each inserted zero, provided the line accepts every bit.
- R3: Each frame goes out as the flag 0,1,1,1,1,1,1,0, then the stuffed payload, then the same flag. The flag bits are never stuffed.
- R4: The count of consecutive payload ones carries across idle cycles of the source and across any byte grouping of the payload.
- R5: Outside a flag, the line never carries more than five consecutive ones.
- R6: The receiver removes any 0 that follows exactly five consecutive 1s.
- R7: The receiver treats 0, six 1s, 0 as a frame boundary. No bit of a flag appears on `d_valid`/`d_bit`, and the payload bits come out in order.
- R8: `frame_start` pulses together with the first output bit of a frame. `frame_end` pulses once per closing flag, and only for a frame that delivered at least one bit.
- R9: A seventh consecutive 1 inside a frame pulses `abort_err` once, discards the held bits, and suppresses `frame_end` and any output until the next flag.
- R10: After reset, `ln_valid`, `s_ready`, `d_valid`, `frame_start`, `frame_end` and `abort_err` are all 0.
- R11: While `ln_valid` is high and `ln_ready` is low, `ln_valid` stays high and `ln_bit` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Payload bit offered |
| s_ready | output | 1 | Payload bit accepted this cycle |
| s_bit | input | 1 | Payload bit value |
| s_last | input | 1 | Offered bit is the final bit of its frame |
| ln_valid | output | 1 | Line bit present |
| ln_ready | input | 1 | Line takes the bit this cycle |
| ln_bit | output | 1 | Transmitted line bit |
| rx_valid | input | 1 | Received line bit present |
| rx_bit | input | 1 | Received line bit value |
| d_valid | output | 1 | Recovered payload bit present |
| d_bit | output | 1 | Recovered payload bit value |
| frame_start | output | 1 | First recovered bit of a frame |
| frame_end | output | 1 | Closing flag of a frame with data |
| abort_err | output | 1 | Seventh consecutive one inside a frame |

## Verification
Suppose the transmit ones counter were wrong. It would add or drop a line zero, and the per-transfer line comparison would catch the shift at the next transfer after the fifth one. It would also move the one-cycle `s_ready` stall to a different position. Suppose instead the receive run counter or hold window were wrong. Flag bits would then leak into the output, or stuffed zeros would survive. The receive side emits with a fixed latency of eight line bits, so the in-order bit comparison shows the fault within eight bits. The `frame_start`/`frame_end` length checks show it no later than the next closing flag.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_CLOSE
  } tx_state_e;

  // Delimiter: a zero, run_len+1 ones, a zero (length run_len+3).
  function automatic logic flag_bit(input int run_len, input int pos);
    return !(pos == 0 || pos == run_len + 2);
  endfunction

endpackage

// File: rtl/hdlc_stuffer.sv
module hdlc_stuffer
  import hdlc_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  input  logic s_last,
  output logic ln_valid,
  input  logic ln_ready,
  output logic ln_bit
);

  localparam int FLAG_LEN = RUN_LEN + 3;
  localparam int CW       = $clog2(RUN_LEN + 1);
  localparam int IW       = $clog2(FLAG_LEN);

  tx_state_e       state;
  logic [CW-1:0]   ones;
  logic [IW-1:0]   idx;
  logic            close_pend;
  logic            ov, ob, ob_data;
  logic            adv, stuff, take;

  assign adv      = !ov || ln_ready;
  assign stuff    = (state == ST_DATA) && (ones == CW'(RUN_LEN));
  assign s_ready  = (state == ST_DATA) && adv && !stuff;
  assign take     = s_valid && s_ready;
  assign ln_valid = ov;
  assign ln_bit   = ob;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ones       <= '0;
      idx        <= '0;
      close_pend <= 1'b0;
      ov         <= 1'b0;
      ob         <= 1'b0;
      ob_data    <= 1'b0;
    end else if (adv) begin
      case (state)
        ST_IDLE: begin
          if (s_valid) begin
            ov      <= 1'b1;
            ob      <= flag_bit(RUN_LEN, 0);
            ob_data <= 1'b0;
            idx     <= IW'(1);
            state   <= ST_OPEN;
          end else begin
            ov <= 1'b0;
          end
        end
        ST_OPEN: begin
          ov      <= 1'b1;
          ob      <= flag_bit(RUN_LEN, int'(idx));
          ob_data <= 1'b0;
          ones    <= '0;
          if (idx == IW'(FLAG_LEN - 1)) begin
            idx   <= '0;
            state <= ST_DATA;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_DATA: begin
          if (stuff) begin
            ov      <= 1'b1;
            ob      <= 1'b0;
            ob_data <= 1'b1;
            ones    <= '0;
            if (close_pend) begin
              close_pend <= 1'b0;
              state      <= ST_CLOSE;
            end
          end else if (s_valid) begin
            ov      <= 1'b1;
            ob      <= s_bit;
            ob_data <= 1'b1;
            ones    <= s_bit ? ones + CW'(1) : '0;
            if (s_last) begin
              if (s_bit && ones == CW'(RUN_LEN - 1)) close_pend <= 1'b1;
              else                                   state      <= ST_CLOSE;
            end
          end else begin
            ov <= 1'b0;
          end
        end
        ST_CLOSE: begin
          ov      <= 1'b1;
          ob      <= flag_bit(RUN_LEN, int'(idx));
          ob_data <= 1'b0;
          if (idx == IW'(FLAG_LEN - 1)) begin
            idx   <= '0;
            state <= ST_IDLE;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Run of payload ones actually handed to the line (flags excluded).
  logic [CW:0] line_run;
  always_ff @(posedge clk) begin
    if (rst)                line_run <= '0;
    else if (ov && ln_ready) line_run <= (ob_data && ob) ? line_run + (CW+1)'(1) : '0;
  end

  a_r5_no_long_run: assert property (@(posedge clk) disable iff (rst)
    line_run <= (CW+1)'(RUN_LEN));

  a_r2_stall_after_run: assert property (@(posedge clk) disable iff (rst)
    (take && s_bit && ones == CW'(RUN_LEN - 1)) |=> !s_ready);

  a_r11_hold_line: assert property (@(posedge clk) disable iff (rst)
    (ln_valid && !ln_ready) |=> (ln_valid && $stable(ln_bit)));

endmodule

// File: rtl/hdlc_destuffer.sv
module hdlc_destuffer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic d_valid,
  output logic d_bit,
  output logic frame_start,
  output logic frame_end,
  output logic abort_err
);

  localparam int DEPTH = RUN_LEN + 3;
  localparam int CW    = $clog2(RUN_LEN + 3);

  logic [CW-1:0]    ones;
  logic [DEPTH-1:0] pbit, pkeep;
  logic             in_frame, got;
  logic             hit_flag, hit_stuff, hit_abort, out_keep, new_keep;

  assign hit_flag  = rx_valid && !rx_bit && (ones == CW'(RUN_LEN + 1));
  assign hit_stuff = rx_valid && !rx_bit && (ones == CW'(RUN_LEN));
  assign hit_abort = rx_valid &&  rx_bit && (ones == CW'(RUN_LEN + 1)) && in_frame;
  assign out_keep  = rx_valid && pkeep[DEPTH-1] && !hit_abort;
  assign new_keep  = in_frame && !hit_stuff && !hit_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones        <= '0;
      pbit        <= '0;
      pkeep       <= '0;
      in_frame    <= 1'b0;
      got         <= 1'b0;
      d_valid     <= 1'b0;
      d_bit       <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      abort_err   <= 1'b0;
    end else begin
      d_valid     <= out_keep;
      d_bit       <= pbit[DEPTH-1];
      frame_start <= out_keep && !got;
      frame_end   <= hit_flag && in_frame && (got || out_keep);
      abort_err   <= hit_abort;
      if (rx_valid) begin
        if (!rx_bit)                            ones <= '0;
        else if (ones != CW'(RUN_LEN + 2))      ones <= ones + CW'(1);
        pbit <= {pbit[DEPTH-2:0], rx_bit};
        if (hit_flag || hit_abort) pkeep <= '0;
        else                       pkeep <= {pkeep[DEPTH-2:0], new_keep};
        if (hit_flag) begin
          in_frame <= 1'b1;
          got      <= 1'b0;
        end else if (hit_abort) begin
          in_frame <= 1'b0;
          got      <= 1'b0;
        end else if (out_keep) begin
          got <= 1'b1;
        end
      end
    end
  end

  a_r8_start_has_data: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> d_valid);

  a_r9_abort_silent: assert property (@(posedge clk) disable iff (rst)
    abort_err |=> (!d_valid && !frame_end));

  a_r8_end_spaced: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

endmodule

// File: rtl/hdlc_bit_framer.sv
module hdlc_bit_framer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  input  logic s_last,
  output logic ln_valid,
  input  logic ln_ready,
  output logic ln_bit,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic d_valid,
  output logic d_bit,
  output logic frame_start,
  output logic frame_end,
  output logic abort_err
);

  hdlc_stuffer #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_bit    (s_bit),
    .s_last   (s_last),
    .ln_valid (ln_valid),
    .ln_ready (ln_ready),
    .ln_bit   (ln_bit)
  );

  hdlc_destuffer #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_bit      (rx_bit),
    .d_valid     (d_valid),
    .d_bit       (d_bit),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .abort_err   (abort_err)
  );

endmodule

// File: tb/hdlc_bit_framer_test.sv
module hdlc_bit_framer_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_bit = 1'b0, s_last = 1'b0;
  logic s_ready, ln_valid, ln_bit;
  logic ln_ready = 1'b1;
  logic d_valid, d_bit, frame_start, frame_end, abort_err;
  logic direct = 1'b0, drv_rx_valid = 1'b0, drv_rx_bit = 1'b0;
  logic rx_valid_w, rx_bit_w;

  assign rx_valid_w = direct ? drv_rx_valid : (ln_valid && ln_ready);
  assign rx_bit_w   = direct ? drv_rx_bit   : ln_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_bit_framer uut (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit), .s_last(s_last),
    .ln_valid(ln_valid), .ln_ready(ln_ready), .ln_bit(ln_bit),
    .rx_valid(rx_valid_w), .rx_bit(rx_bit_w),
    .d_valid(d_valid), .d_bit(d_bit),
    .frame_start(frame_start), .frame_end(frame_end), .abort_err(abort_err)
  );

  int checks = 0, fails = 0;
  bit txq[$];
  bit rxq[$];
  int lenq[$];
  int seen_aborts = 0, bits_in_frame = 0;
  bit started = 0, bp_mode = 0, prev_hold = 0, prev_bit = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Line back-pressure pattern
  always @(negedge clk) begin
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ln_ready = bp_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // Reference comparison every cycle
  always @(negedge clk) begin
    #2;
    if (started) begin
      if (prev_hold) check(ln_valid && ln_bit == prev_bit, "R11 hold", int'(ln_bit), int'(prev_bit));
      prev_hold = ln_valid && !ln_ready;
      prev_bit  = ln_bit;
      if (ln_valid && ln_ready) begin
        if (txq.size() == 0) check(0, "R3 extra line bit", 1, 0);
        else begin
          automatic bit e = txq.pop_front();
          check(ln_bit == e, "R1 R3 R5 line bit", int'(ln_bit), int'(e));
        end
      end
      if (d_valid) begin
        if (rxq.size() == 0) check(0, "R7 extra output bit", 1, 0);
        else begin
          automatic bit e = rxq.pop_front();
          check(d_bit == e, "R6 R7 payload bit", int'(d_bit), int'(e));
        end
        check(frame_start == (bits_in_frame == 0), "R8 frame_start", int'(frame_start), int'(bits_in_frame == 0));
        bits_in_frame++;
      end else if (frame_start) begin
        check(0, "R8 frame_start without data", 1, 0);
      end
      if (frame_end) begin
        if (lenq.size() == 0) check(0, "R8 unexpected frame_end", 1, 0);
        else begin
          automatic int l = lenq.pop_front();
          check(bits_in_frame == l, "R8 frame length", bits_in_frame, l);
        end
        bits_in_frame = 0;
      end
      if (abort_err) seen_aborts++;
    end
  end

  task automatic send_frame(input bit pl[$], input int gap_at, input int gap_len, input bit chk);
    int run = 0;
    int waits;
    int exp;
    // expected line image
    for (int k = 0; k < 8; k++) txq.push_back((k == 0 || k == 7) ? 1'b0 : 1'b1);
    for (int k = 0; k < pl.size(); k++) begin
      txq.push_back(pl[k]);
      run = pl[k] ? run + 1 : 0;
      if (run == 5) begin txq.push_back(1'b0); run = 0; end
    end
    for (int k = 0; k < 8; k++) txq.push_back((k == 0 || k == 7) ? 1'b0 : 1'b1);
    for (int k = 0; k < pl.size(); k++) rxq.push_back(pl[k]);
    lenq.push_back(pl.size());
    // drive
    run = 0;
    for (int i = 0; i < pl.size(); i++) begin
      @(negedge clk);
      if (i == gap_at) begin
        s_valid = 1'b0;
        repeat (gap_len) @(negedge clk);
      end
      s_valid = 1'b1;
      s_bit   = pl[i];
      s_last  = (i == pl.size() - 1);
      waits   = 0;
      #1;
      while (!s_ready) begin
        @(negedge clk);
        #1;
        waits++;
      end
      exp = (run == 5) ? 1 : 0;
      if (chk && i > 0 && i != gap_at) check(waits == exp, "R2 stall length", waits, exp);
      if (run == 5) run = 0;
      run = pl[i] ? run + 1 : 0;
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic rx_send(input bit b);
    @(negedge clk);
    drv_rx_valid = 1'b1;
    drv_rx_bit   = b;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((txq.size() != 0 || lenq.size() != 0) && n < 400) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(txq.size() == 0 && lenq.size() == 0 && rxq.size() == 0, req, txq.size() + lenq.size() + rxq.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    bit f[$];
    int unsigned seed = 32'h1234;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R10 reset state
    check(!ln_valid, "R10 ln_valid", int'(ln_valid), 0);
    check(!s_ready, "R10 s_ready", int'(s_ready), 0);
    check(!d_valid && !frame_start && !frame_end && !abort_err, "R10 rx outputs",
          int'({d_valid, frame_start, frame_end, abort_err}), 0);
    started = 1;

    f = '{1, 0, 1, 1, 0, 0, 1, 0};               send_frame(f, -1, 0, 1);   // R3 plain frame
    f = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};   send_frame(f, -1, 0, 1);   // R1 R6 double stuffing
    f = '{0, 1, 1, 1, 1, 1};                     send_frame(f, -1, 0, 1);   // R1 stuff after last bit
    f = '{0, 1, 1, 1, 1, 1, 1, 0};               send_frame(f, 4, 3, 1);    // R4 run across source gap
    drain("R4 loopback drained");

    bp_mode = 1;                                                            // R11 back-pressure
    f = {};
    for (int k = 0; k < 40; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      f.push_back(((seed >> 16) % 4) != 0);
    end
    send_frame(f, -1, 0, 0);
    drain("R11 back-pressure frame drained");
    bp_mode = 0;

    f = '{1, 1, 1, 1, 1, 1, 1};                  send_frame(f, -1, 0, 1);   // R5 seven payload ones
    f = '{1};                                    send_frame(f, -1, 0, 1);   // R8 single-bit frame
    drain("R8 consecutive frames drained");

    // R9 abort then recovery, driven directly on the receive side
    direct = 1'b1;
    for (int k = 0; k < 8; k++) rx_send((k == 0 || k == 7) ? 1'b0 : 1'b1);
    for (int k = 0; k < 9; k++) rx_send(1'b1);
    for (int k = 0; k < 8; k++) rx_send((k == 0 || k == 7) ? 1'b0 : 1'b1);
    rxq.push_back(0); rxq.push_back(1); rxq.push_back(1); rxq.push_back(0);
    lenq.push_back(4);
    rx_send(0); rx_send(1); rx_send(1); rx_send(0);
    for (int k = 0; k < 8; k++) rx_send((k == 0 || k == 7) ? 1'b0 : 1'b1);
    @(negedge clk);
    drv_rx_valid = 1'b0;
    drain("R9 recovery frame drained");
    check(seen_aborts == 1, "R9 abort count", seen_aborts, 1);

    summary();
  end

endmodule